// File: doc/BRIEF.md
# Segmented Base-Bound Address Relocator

This block maps a 16-bit logical address onto a 20-bit physical address through a table of four segment entries that belong to the running process. The two most significant address bits choose an entry. The remaining fourteen bits are an offset inside that segment. Each entry holds a 20-bit base, a 15-bit bound and a valid flag. The block compares the offset with the bound and adds it to the base. An entry that is not valid leaves a hole in the logical space, so any access to that segment is refused.

A request is captured on the clock edge where `req_valid` is high. During the next cycle the block presents either a translated address on `phys_valid`/`phys_addr` or a one-cycle fault pulse with a cause code. Software loads the table one entry per cycle through a write port. To switch processes, software rewrites all four entries.

Top module: `seg_relocator`

## Requirements
- R1: After a synchronous active-low reset every entry is invalid and all outputs are low, so the first request after reset faults with cause 2'b10.
- R2: `req_addr[15:14]` selects the entry and `req_addr[13:0]` is the offset.
- R3: For a valid entry with offset below bound, the cycle after `req_valid` shows `phys_valid`=1 and `phys_addr` = (base + offset) modulo 2^20.
- R4: An offset equal to or greater than the bound of a valid entry gives `fault`=1 with `fault_cause`=2'b01 and no translation. Offset bound-1 still translates.
- R5: A request to an invalid entry gives `fault`=1 with `fault_cause`=2'b10. This cause wins over any bound result.
- R6: Each request gives exactly one of `phys_valid` or `fault`, for one cycle only. With no request, both are low, `phys_addr` is 0 and `fault_cause` is 2'b00.
- R7: A write with `wr_en`=1 replaces base, bound and valid of entry `wr_idx` and leaves the other entries unchanged. A write with `wr_valid`=0 unmaps the segment.
- R8: A write presented in the same cycle as `req_valid` is already in effect for that request. A write presented in the cycle that shows a result does not change that result. It applies from the next cycle on.
- R9: A valid entry with bound 0 faults every offset with cause 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 16 | Logical address |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 2 | Entry to write |
| wr_base | input | 20 | New base address |
| wr_bound | input | 15 | New bound (segment length) |
| wr_valid | input | 1 | New valid flag |
| phys_valid | output | 1 | Translated address present |
| phys_addr | output | 20 | Physical address, 0 when idle |
| fault | output | 1 | Translation refused |
| fault_cause | output | 2 | 01 out of bound, 10 not mapped, 00 none |

## Verification
A table write and a translation read can land in the same cycle on the same entry. The bench provokes this in two ways. In the first case it raises `wr_en` together with `req_valid` for an unmapped segment, and expects the result to use the new entry. In the second case it rewrites that entry to invalid in the cycle that shows a result, and expects that result to keep the old translation. A follow-up request to the same address must then fault as unmapped, which confirms that the write did land.

// File: rtl/seg_reloc_pkg.sv
// Package: shared widths and the fault cause encoding for the relocator.
// Assumes the physical width exceeds the offset width.
package seg_reloc_pkg;
    parameter int unsigned LOG_W_DEF  = 16;
    parameter int unsigned SEG_W_DEF  = 2;
    parameter int unsigned PHYS_W_DEF = 20;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'b00,
        CAUSE_BOUND    = 2'b01,
        CAUSE_UNMAPPED = 2'b10
    } fault_cause_e;
endpackage

// File: rtl/seg_regfile.sv
// Module: per-process segment table, one write port, one combinational read port.
// Assumes a single writer. A write lands at the clock edge, so a read in the
// same cycle still returns the previous contents.
module seg_regfile #(
    parameter int unsigned SEG_W  = 2,
    parameter int unsigned PHYS_W = 20,
    parameter int unsigned BND_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [PHYS_W-1:0] wr_base,
    input  logic [BND_W-1:0]  wr_bound,
    input  logic              wr_valid,
    input  logic [SEG_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [PHYS_W-1:0] rd_base,
    output logic [BND_W-1:0]  rd_bound
);
    localparam int unsigned NSEG = 1 << SEG_W;

    logic [NSEG-1:0]   vld_q;
    logic [PHYS_W-1:0] base_q  [NSEG];
    logic [BND_W-1:0]  bound_q [NSEG];

    for (genvar i = 0; i < NSEG; i++) begin : g_entry
        // Hold one entry; clear its valid flag on reset, load it on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[i]   <= 1'b0;
                base_q[i]  <= '0;
                bound_q[i] <= '0;
            end else if (wr_en && (wr_idx == SEG_W'(i))) begin
                vld_q[i]   <= wr_valid;
                base_q[i]  <= wr_base;
                bound_q[i] <= wr_bound;
            end
        end

        // R7: an entry that is not addressed by a write keeps its contents.
        a_r7_untouched_stable: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_idx == SEG_W'(i))) |=>
                ($stable(vld_q[i]) && $stable(base_q[i]) && $stable(bound_q[i])));
    end

    // Select the entry addressed by the current request.
    always_comb begin
        rd_valid = vld_q[rd_idx];
        rd_base  = base_q[rd_idx];
        rd_bound = bound_q[rd_idx];
    end

    // R1: one cycle of reset leaves every entry unmapped.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (vld_q == '0));
endmodule

// File: rtl/seg_xlate.sv
// Module: combinational check and relocation of one offset against one entry.
// Assumes PHYS_W > OFF_W and BND_W == OFF_W + 1, so that a bound can cover a full segment.
module seg_xlate
    import seg_reloc_pkg::*;
#(
    parameter int unsigned OFF_W  = 14,
    parameter int unsigned PHYS_W = 20,
    parameter int unsigned BND_W  = 15
) (
    input  logic              active,
    input  logic [OFF_W-1:0]  offset,
    input  logic              ent_valid,
    input  logic [PHYS_W-1:0] ent_base,
    input  logic [BND_W-1:0]  ent_bound,
    output logic              ok,
    output logic [PHYS_W-1:0] addr,
    output logic              flt,
    output fault_cause_e      cause
);
    localparam int unsigned PAD_W = PHYS_W - OFF_W;

    logic in_range;
    logic [PHYS_W-1:0] sum;

    // Compare the offset with the bound and form the relocated address.
    always_comb begin
        in_range = ({1'b0, offset} < ent_bound);
        sum      = ent_base + {{PAD_W{1'b0}}, offset};
    end

    // Decide the outcome. An unmapped entry takes priority over the bound check.
    always_comb begin
        ok    = 1'b0;
        flt   = 1'b0;
        addr  = '0;
        cause = CAUSE_NONE;
        if (active) begin
            if (!ent_valid) begin
                flt   = 1'b1;
                cause = CAUSE_UNMAPPED;
            end else if (!in_range) begin
                flt   = 1'b1;
                cause = CAUSE_BOUND;
            end else begin
                ok   = 1'b1;
                addr = sum;
            end
        end
    end
endmodule

// File: rtl/seg_relocator.sv
// Module: top of the segmented base-bound relocator. It registers the request,
// reads the segment table and presents the translation or the fault in the
// following cycle. Assumes the table is loaded before use; reset leaves every segment unmapped.
module seg_relocator
    import seg_reloc_pkg::*;
#(
    parameter int unsigned LOG_W  = LOG_W_DEF,
    parameter int unsigned SEG_W  = SEG_W_DEF,
    parameter int unsigned PHYS_W = PHYS_W_DEF,
    localparam int unsigned OFF_W = LOG_W - SEG_W,
    localparam int unsigned BND_W = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LOG_W-1:0]  req_addr,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [PHYS_W-1:0] wr_base,
    input  logic [BND_W-1:0]  wr_bound,
    input  logic              wr_valid,
    output logic              phys_valid,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              fault,
    output logic [1:0]        fault_cause
);
    logic              req_q;
    logic [LOG_W-1:0]  addr_q;
    logic              ent_valid;
    logic [PHYS_W-1:0] ent_base;
    logic [BND_W-1:0]  ent_bound;
    fault_cause_e      cause;

    // Capture the request; it lives for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            req_q  <= req_valid;
            addr_q <= req_valid ? req_addr : addr_q;
        end
    end

    seg_regfile #(
        .SEG_W  (SEG_W),
        .PHYS_W (PHYS_W),
        .BND_W  (BND_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_base  (wr_base),
        .wr_bound (wr_bound),
        .wr_valid (wr_valid),
        .rd_idx   (addr_q[LOG_W-1 -: SEG_W]),
        .rd_valid (ent_valid),
        .rd_base  (ent_base),
        .rd_bound (ent_bound)
    );

    seg_xlate #(
        .OFF_W  (OFF_W),
        .PHYS_W (PHYS_W),
        .BND_W  (BND_W)
    ) u_xlate (
        .active    (req_q),
        .offset    (addr_q[OFF_W-1:0]),
        .ent_valid (ent_valid),
        .ent_base  (ent_base),
        .ent_bound (ent_bound),
        .ok        (phys_valid),
        .addr      (phys_addr),
        .flt       (fault),
        .cause     (cause)
    );

    // Put the cause code on the port.
    always_comb fault_cause = cause;

    // R6: a translation and a fault never appear together.
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(phys_valid && fault));

    // R6: every request produces one outcome in the next cycle.
    a_r6_one_per_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (phys_valid ^ fault));

    // R6: without a request, nothing appears in the next cycle.
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!phys_valid && !fault && (phys_addr == '0)));

    // R4: a translation comes only from an offset below the bound.
    a_r4_in_bound: assert property (@(posedge clk) disable iff (!rst_n)
        phys_valid |-> ({1'b0, addr_q[OFF_W-1:0]} < ent_bound));

    // R5: an unmapped cause comes only from an invalid entry.
    a_r5_unmapped_src: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && (fault_cause == 2'b10)) |-> !ent_valid);

    // R4: a fault always carries a non-zero cause.
    a_r4_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_cause != 2'b00));
endmodule

// File: tb/seg_relocator_bench.sv
`timescale 1ns/1ps
module seg_relocator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [19:0] wr_base = '0;
    logic [14:0] wr_bound = '0;
    logic        wr_valid = 1'b0;
    logic        phys_valid;
    logic [19:0] phys_addr;
    logic        fault;
    logic [1:0]  fault_cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    seg_relocator u_seg_relocator (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base), .wr_bound(wr_bound),
        .wr_valid(wr_valid), .phys_valid(phys_valid), .phys_addr(phys_addr),
        .fault(fault), .fault_cause(fault_cause)
    );

    // {addr, phys_valid, phys_addr, cause}; fault is expected when cause != 0
    localparam int NV = 9;
    localparam logic [38:0] VEC [NV] = '{
        {16'h0000, 1'b1, 20'h10000, 2'b00},  // R3 R2 seg0 start
        {16'h0FFF, 1'b1, 20'h10FFF, 2'b00},  // R4 last in-bound offset
        {16'h1000, 1'b0, 20'h00000, 2'b01},  // R4 offset == bound
        {16'h4123, 1'b1, 20'hFF123, 2'b00},  // R2 seg1
        {16'h6000, 1'b1, 20'h01000, 2'b00},  // R3 wrap modulo 2^20
        {16'h7FFF, 1'b1, 20'h02FFF, 2'b00},  // R3 top offset, wrapped
        {16'h8000, 1'b0, 20'h00000, 2'b10},  // R5 unmapped seg2
        {16'hC000, 1'b0, 20'h00000, 2'b01},  // R9 bound 0
        {16'hFFFF, 1'b0, 20'h00000, 2'b01}   // R9 bound 0 top
    };

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] outs();
        return {phys_valid, phys_addr, fault, fault_cause};
    endfunction

    function automatic logic [23:0] expv(input logic pv, input logic [19:0] pa, input logic [1:0] c);
        return {pv, pa, (c != 2'b00), c};
    endfunction

    task automatic write_ent(input logic [1:0] i, input logic [19:0] b,
                             input logic [14:0] bd, input logic v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_base = b; wr_bound = bd; wr_valid = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic request(input logic [15:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle during and after reset
        chk("R1 reset outputs", outs(), expv(1'b0, 20'h0, 2'b00));
        rst_n = 1'b1;
        request(16'h0000);
        chk("R1 unmapped after reset", outs(), expv(1'b0, 20'h0, 2'b10));
        @(negedge clk);
        chk("R6 idle after result", outs(), expv(1'b0, 20'h0, 2'b00));

        // R7: load the table
        write_ent(2'd0, 20'h10000, 15'h1000, 1'b1);
        write_ent(2'd1, 20'hFF000, 15'h4000, 1'b1);
        write_ent(2'd2, 20'h30000, 15'h4000, 1'b0);
        write_ent(2'd3, 20'h00400, 15'h0000, 1'b1);

        for (int k = 0; k < NV; k++) begin
            request(VEC[k][38:23]);
            chk($sformatf("R3/R4/R5/R9 vector %0d", k), outs(),
                expv(VEC[k][22], VEC[k][21:2], VEC[k][1:0]));
        end

        // R6: back-to-back requests each give one result
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h0010;
        @(negedge clk);
        req_addr = 16'h8000;
        chk("R6 back-to-back first", outs(), expv(1'b1, 20'h10010, 2'b00));
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6 back-to-back second", outs(), expv(1'b0, 20'h0, 2'b10));
        @(negedge clk);
        chk("R6 no request no output", outs(), expv(1'b0, 20'h0, 2'b00));

        // R8: write together with the request is already visible
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h8010;
        wr_en = 1'b1; wr_idx = 2'd2; wr_base = 20'h20000; wr_bound = 15'h0100; wr_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        chk("R8 write with request", outs(), expv(1'b1, 20'h20010, 2'b00));

        // R8: write in the result cycle does not disturb the shown result
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h8020;
        @(negedge clk);
        req_valid = 1'b0;
        wr_en = 1'b1; wr_idx = 2'd2; wr_valid = 1'b0;
        #1;
        chk("R8 write in result cycle", outs(), expv(1'b1, 20'h20020, 2'b00));
        @(negedge clk);
        wr_en = 1'b0;
        request(16'h8020);
        chk("R8 later request sees write", outs(), expv(1'b0, 20'h0, 2'b10));

        // R7: unmapping seg0 leaves seg1 alone
        write_ent(2'd0, 20'h10000, 15'h1000, 1'b0);
        request(16'h0000);
        chk("R7 unmapped by write", outs(), expv(1'b0, 20'h0, 2'b10));
        request(16'h4123);
        chk("R7 other entry kept", outs(), expv(1'b1, 20'hFF123, 2'b00));

        // R4: bound just above the offset, then equal to it
        write_ent(2'd3, 20'h00400, 15'h0006, 1'b1);
        request(16'hC005);
        chk("R4 offset bound-1", outs(), expv(1'b1, 20'h00405, 2'b00));
        request(16'hC006);
        chk("R4 offset == bound", outs(), expv(1'b0, 20'h0, 2'b01));

        // R1: reset again clears the table
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        request(16'h4123);
        chk("R1 reset unmaps table", outs(), expv(1'b0, 20'h0, 2'b10));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule